// File: doc/BRIEF.md
# Shared-Memory Host Access Arbiter

This block is the host-facing slave port of a shared 16-bit storage unit. A word-wide RAM and a small register file sit behind it. The RAM is shared with an internal protocol engine, and the engine always wins. A host starts a transfer by pulling its select and strobe lines low. The block grants the transfer by pulling an active-low I/O enable low, but only on a clock edge where the engine is not claiming the RAM. After a grant, the port freezes its control and address inputs at fixed clock edges. It then answers with an active-low ready after a fixed number of clocks. Register transfers finish sooner than RAM transfers.

Reads place the selected word on a shared tri-state data bus while ready is low. Writes take the bus value into the selected location on the edge that asserts ready. The host ends every transfer by raising strobe, which returns the port to idle. A single busy input stands in for the protocol engine. A strap input chooses the sense of the read/write line.

Top module: `host_share_port`

## Requirements
- R1: ioEnN falls on the first rising clock edge where selN, strbN and engineBusy are all sampled low. If selN or strbN is high, no grant occurs.
- R2: While engineBusy is high, ioEnN stays high however long the wait lasts. The grant comes on the first rising edge after engineBusy is sampled low.
- R3: Once ioEnN is low, the host may raise selN and the transfer still completes.
- R4: memSel and rdWr follow their pins until the first falling clock edge after ioEnN goes low. From that edge to the end of the transfer, they hold their captured values.
- R5: addr follows its pins until the first rising clock edge after ioEnN goes low. From that edge to the end of the transfer, it holds its captured value.
- R6: readyN falls REG_LAT (default 3) rising edges after the edge that lowered ioEnN for a register transfer (memSel=0). It falls RAM_LAT (default 7) edges after that edge for a RAM transfer (memSel=1).
- R7: A transfer is a read when rdWr equals rdPol: rdWr=1 reads when rdPol=1, and rdWr=0 reads when rdPol=0. Any other combination is a write.
- R8: On the first rising edge where strbN is sampled high during a transfer, ioEnN and readyN both go high. The port stops driving dataBus as soon as strbN is high.
- R9: A write stores dataBus into the selected word on the edge where readyN falls. A read drives the selected word on dataBus while readyN is low. memSel=1 selects the RAM and memSel=0 selects the register file; the two are separate spaces.
- R10: RAM transfers decode only addr[13:0], of which the low RAM_AW bits index the storage. Register transfers decode only addr[4:0]. All other address bits are ignored.
- R11: After reset, ioEnN and readyN are high, dataBus is not driven, and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selN | input | 1 | Active-low host select |
| strbN | input | 1 | Active-low host strobe; rising ends a transfer |
| engineBusy | input | 1 | High while the internal engine claims the RAM |
| memSel | input | 1 | 1 = RAM transfer, 0 = register transfer |
| rdWr | input | 1 | Read/write line, sense set by rdPol |
| rdPol | input | 1 | Read/write polarity strap |
| addr | input | 16 | Host word address |
| ioEnN | output | 1 | Active-low grant, low for the whole transfer |
| readyN | output | 1 | Active-low transfer-complete handshake |
| dataBus | inout | 16 | Shared bidirectional data bus |

## Verification
A broken grant or latency counter shows up as an unexpected number of clock edges between the host request, the falling ioEnN and the falling readyN. The bench measures this in whole cycles on every transfer, so the fault appears within the first access. A capture latch that stays transparent shows up after the host deliberately scrambles memSel, rdWr and addr following each capture edge. The result is a wrong latency, a write into the wrong space, or wrong read data on the very next readback. A port that holds the bus after strobe rises corrupts a value the bench drives onto dataBus one step later.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  typedef struct packed {
    logic xferOn;    // grant held (ioEnN low)
    logic storeNow;  // write the selected word at this rising edge
    logic driveOut;  // put read data on the bus
  } hspStrobe_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_DONE = 2'd2
  } hspState_t;
endpackage

// File: rtl/hsp_ctrl.sv
module hsp_ctrl
  import hsp_pkg::*;
#(
  parameter int REG_LAT = 3,
  parameter int RAM_LAT = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selN,
  input  logic       strbN,
  input  logic       engineBusy,
  input  logic       isMem,
  input  logic       isRead,
  output logic       ioEnN,
  output logic       readyN,
  output hspStrobe_t stb
);
  localparam int MAX_LAT = (RAM_LAT > REG_LAT) ? RAM_LAT : REG_LAT;
  localparam int CW      = $clog2(MAX_LAT + 1);

  hspState_t      state;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  target;
  logic           hit;

  assign target = isMem ? CW'(RAM_LAT) : CW'(REG_LAT);
  assign hit    = (cnt == target);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      ioEnN  <= 1'b1;
      readyN <= 1'b1;
      cnt    <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (!selN && !strbN && !engineBusy) begin
            state <= S_WAIT;
            ioEnN <= 1'b0;
            cnt   <= CW'(1);
          end
        end
        S_WAIT: begin
          if (strbN) begin
            state  <= S_IDLE;
            ioEnN  <= 1'b1;
            readyN <= 1'b1;
          end else if (hit) begin
            state  <= S_DONE;
            readyN <= 1'b0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_DONE: begin
          if (strbN) begin
            state  <= S_IDLE;
            ioEnN  <= 1'b1;
            readyN <= 1'b1;
          end
        end
        default: begin
          state  <= S_IDLE;
          ioEnN  <= 1'b1;
          readyN <= 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    stb.xferOn   = (state != S_IDLE);
    stb.storeNow = (state == S_WAIT) && !strbN && hit && !isRead;
    stb.driveOut = (state == S_DONE) && !strbN && isRead;
  end

  // R1: a grant only follows a free, fully requested edge
  p_grant_free_r1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ioEnN) |-> ($past(!engineBusy) && $past(!selN) && $past(!strbN)));

  // R2: engine activity holds the host off
  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ioEnN && engineBusy) |=> ioEnN);

  // R6: ready only inside a granted transfer
  p_ready_inside_r6: assert property (@(posedge clk) disable iff (!rstN)
    !readyN |-> !ioEnN);

  // R6: ready never arrives earlier than three edges after the grant
  p_min_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyN) |-> ($past(!ioEnN) && $past(!ioEnN, 3)));

  // R8: strobe high ends the transfer at the next edge
  p_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strbN && !ioEnN) |=> (ioEnN && readyN));
endmodule

// File: rtl/hsp_datapath.sv
module hsp_datapath
  import hsp_pkg::*;
#(
  parameter int DW     = 16,
  parameter int AW     = 16,
  parameter int RAM_AW = 10,
  parameter int REG_AW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  hspStrobe_t    stb,
  input  logic          memSelIn,
  input  logic          rdWrIn,
  input  logic          rdPol,
  input  logic [AW-1:0] addrIn,
  input  logic [DW-1:0] busIn,
  output logic          isMem,
  output logic          isRead,
  output logic [DW-1:0] rdData,
  output logic          oe
);
  localparam int RAM_N = 1 << RAM_AW;
  localparam int REG_N = 1 << REG_AW;

  // control capture: transparent until first falling edge of a transfer
  logic ctlHeld, memSelLat, rdWrLat, rdWrEff;
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlHeld   <= 1'b0;
      memSelLat <= 1'b0;
      rdWrLat   <= 1'b0;
    end else begin
      if (!ctlHeld) begin
        memSelLat <= memSelIn;
        rdWrLat   <= rdWrIn;
      end
      ctlHeld <= stb.xferOn;
    end
  end

  assign isMem   = ctlHeld ? memSelLat : memSelIn;
  assign rdWrEff = ctlHeld ? rdWrLat   : rdWrIn;
  assign isRead  = (rdWrEff == rdPol);

  // address capture: transparent until first rising edge after grant
  logic          addrHeld;
  logic [AW-1:0] addrLat, addrEff;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHeld <= 1'b0;
      addrLat  <= '0;
    end else if (!stb.xferOn) begin
      addrHeld <= 1'b0;
    end else if (!addrHeld) begin
      addrHeld <= 1'b1;
      addrLat  <= addrIn;
    end
  end

  assign addrEff = addrHeld ? addrLat : addrIn;

  logic [RAM_AW-1:0] ramIdx;
  logic [REG_AW-1:0] regIdx;
  assign ramIdx = addrEff[RAM_AW-1:0];
  assign regIdx = addrEff[REG_AW-1:0];

  generate
    if (RAM_AW < AW) begin : g_unusedHi
      logic unusedAddrHi;
      assign unusedAddrHi = ^addrEff[AW-1:RAM_AW];
    end
  endgenerate

  logic [DW-1:0] ramMem  [RAM_N];
  logic [DW-1:0] regFile [REG_N];

  always_ff @(posedge clk) begin
    if (stb.storeNow && isMem) ramMem[ramIdx] <= busIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_N; i++) regFile[i] <= '0;
    end else if (stb.storeNow && !isMem) begin
      regFile[regIdx] <= busIn;
    end
  end

  assign rdData = isMem ? ramMem[ramIdx] : regFile[regIdx];
  assign oe     = stb.driveOut;

  // R4: captured control stays frozen once the transfer is under way
  p_ctl_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.xferOn && $past(stb.xferOn) && $past(stb.xferOn, 2))
      |-> ($stable(isMem) && $stable(rdWrEff)));

  // R5: captured address stays frozen once the transfer is under way
  p_addr_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.xferOn && $past(stb.xferOn) && $past(stb.xferOn, 2))
      |-> $stable(addrEff));
endmodule

// File: rtl/host_share_port.sv
module host_share_port
  import hsp_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 16,
  parameter int RAM_AW  = 10,
  parameter int REG_AW  = 5,
  parameter int REG_LAT = 3,
  parameter int RAM_LAT = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          selN,
  input  logic          strbN,
  input  logic          engineBusy,
  input  logic          memSel,
  input  logic          rdWr,
  input  logic          rdPol,
  input  logic [AW-1:0] addr,
  output logic          ioEnN,
  output logic          readyN,
  inout  wire  [DW-1:0] dataBus
);
  hspStrobe_t    stb;
  logic          isMem, isRead, oe;
  logic [DW-1:0] rdData;

  hsp_ctrl #(.REG_LAT(REG_LAT), .RAM_LAT(RAM_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .selN(selN), .strbN(strbN),
    .engineBusy(engineBusy), .isMem(isMem), .isRead(isRead),
    .ioEnN(ioEnN), .readyN(readyN), .stb(stb)
  );

  hsp_datapath #(.DW(DW), .AW(AW), .RAM_AW(RAM_AW), .REG_AW(REG_AW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .memSelIn(memSel), .rdWrIn(rdWr),
    .rdPol(rdPol), .addrIn(addr), .busIn(dataBus), .isMem(isMem),
    .isRead(isRead), .rdData(rdData), .oe(oe)
  );

  assign dataBus = oe ? rdData : {DW{1'bz}};
endmodule

// File: tb/host_share_port_test.sv
`timescale 1ns/1ps
module host_share_port_test;
  logic        clk = 1'b0;
  logic        rstN, selN, strbN, engineBusy, memSel, rdWr, rdPol;
  logic [15:0] addr, tbDrive;
  logic        tbOe;
  logic        ioEnN, readyN;
  wire  [15:0] dataBus;
  int          nChecks = 0, nFails = 0;
  bit          finished = 1'b0;

  assign dataBus = tbOe ? tbDrive : 16'hzzzz;
  always #10 clk = ~clk;

  host_share_port uut (
    .clk(clk), .rstN(rstN), .selN(selN), .strbN(strbN), .engineBusy(engineBusy),
    .memSel(memSel), .rdWr(rdWr), .rdPol(rdPol), .addr(addr),
    .ioEnN(ioEnN), .readyN(readyN), .dataBus(dataBus)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #15;
  endtask

  // bench drives a pattern and reads it back: fails if the port still drives
  task automatic busFree(input string tag);
    tbDrive = 16'h5AA5;
    tbOe    = 1'b1;
    #1;
    check(dataBus === 16'h5AA5, tag, dataBus, 16'h5AA5);
    tbOe = 1'b0;
  endtask

  // one full transfer; returns read data, ready latency and grant wait
  task automatic doAccess(input logic mem, input logic wr, input logic [15:0] a,
                          input logic [15:0] wd, input logic pol,
                          output logic [15:0] rd, output int lat, output int gWait);
    rdPol   = pol;
    memSel  = mem;
    rdWr    = wr ? ~pol : pol;
    addr    = a;
    tbDrive = wd;
    tbOe    = wr;
    selN    = 1'b0;
    strbN   = 1'b0;
    gWait   = 0;
    do begin tick(); gWait++; end while (ioEnN && gWait < 300);
    // R3: drop select; R4: scramble control after its capture edge
    selN   = 1'b1;
    memSel = ~mem;
    rdWr   = ~rdWr;
    lat    = 0;
    do begin
      tick();
      lat++;
      if (lat == 1) addr = ~a;  // R5: scramble after address capture edge
    end while (readyN && lat < 50);
    rd    = dataBus;
    strbN = 1'b1;
    tbOe  = 1'b0;
    busFree("R8 bus released on strobe");
    tick();
    check(ioEnN && readyN, "R8 idle after strobe", {ioEnN, readyN}, 2'b11);
    addr = 16'h0;
  endtask

  task automatic tReset();
    logic [15:0] rd; int lat, gw;
    check(ioEnN === 1'b1, "R11 ioEnN after reset", ioEnN, 1);
    check(readyN === 1'b1, "R11 readyN after reset", readyN, 1);
    busFree("R11 bus free after reset");
    doAccess(1'b0, 1'b0, 16'h0011, 16'h0, 1'b1, rd, lat, gw);
    check(rd === 16'h0000, "R11 register zero after reset", rd, 0);
  endtask

  task automatic tNoGrant();
    selN = 1'b1; strbN = 1'b0;
    repeat (4) tick();
    check(ioEnN === 1'b1, "R1 no grant without select", ioEnN, 1);
    selN = 1'b0; strbN = 1'b1;
    repeat (4) tick();
    check(ioEnN === 1'b1, "R1 no grant without strobe", ioEnN, 1);
    selN = 1'b1;
    tick();
  endtask

  task automatic tRegRw();
    logic [15:0] rd; int lat, gw;
    doAccess(1'b0, 1'b1, 16'h0009, 16'h1234, 1'b1, rd, lat, gw);
    check(gw == 1, "R1 uncontended grant on first edge", gw, 1);
    check(lat == 3, "R6 register write latency", lat, 3);
    doAccess(1'b0, 1'b0, 16'h0009, 16'h0, 1'b1, rd, lat, gw);
    check(lat == 3, "R6 register read latency (R4 control held)", lat, 3);
    check(rd === 16'h1234, "R9 register readback (R3 select dropped)", rd, 16'h1234);
  endtask

  task automatic tRamRw();
    logic [15:0] rd; int lat, gw;
    doAccess(1'b1, 1'b1, 16'h0100, 16'hBEEF, 1'b1, rd, lat, gw);
    check(lat == 7, "R6 RAM write latency", lat, 7);
    doAccess(1'b1, 1'b0, 16'h0100, 16'h0, 1'b1, rd, lat, gw);
    check(lat == 7, "R6 RAM read latency (R4 control held)", lat, 7);
    check(rd === 16'hBEEF, "R9 RAM readback (R5 address held)", rd, 16'hBEEF);
    doAccess(1'b0, 1'b0, 16'h0009, 16'h0, 1'b1, rd, lat, gw);
    check(rd === 16'h1234, "R9 register space untouched by RAM write", rd, 16'h1234);
  endtask

  task automatic tPolarity();
    logic [15:0] rd; int lat, gw;
    doAccess(1'b0, 1'b1, 16'h0002, 16'h0F0F, 1'b0, rd, lat, gw);
    doAccess(1'b0, 1'b0, 16'h0002, 16'h0, 1'b0, rd, lat, gw);
    check(rd === 16'h0F0F, "R7 low-sense read", rd, 16'h0F0F);
    doAccess(1'b0, 1'b0, 16'h0002, 16'h0, 1'b1, rd, lat, gw);
    check(rd === 16'h0F0F, "R7 high-sense read", rd, 16'h0F0F);
  endtask

  task automatic tDecode();
    logic [15:0] rd; int lat, gw;
    doAccess(1'b1, 1'b1, 16'hC0AA, 16'h7777, 1'b1, rd, lat, gw);
    doAccess(1'b1, 1'b0, 16'h00AA, 16'h0, 1'b1, rd, lat, gw);
    check(rd === 16'h7777, "R10 RAM ignores addr[15:14]", rd, 16'h7777);
    doAccess(1'b0, 1'b1, 16'hFFE3, 16'h3333, 1'b1, rd, lat, gw);
    doAccess(1'b0, 1'b0, 16'h0003, 16'h0, 1'b1, rd, lat, gw);
    check(rd === 16'h3333, "R10 register ignores addr[15:5]", rd, 16'h3333);
  endtask

  task automatic tContention();
    logic [15:0] rd; int lat, gw;
    engineBusy = 1'b1;
    fork
      doAccess(1'b1, 1'b0, 16'h0100, 16'h0, 1'b1, rd, lat, gw);
      begin
        repeat (84) @(posedge clk);
        #15 engineBusy = 1'b0;
      end
    join
    check(gw == 85, "R2 grant on edge after engine frees RAM", gw, 85);
    check(lat == 7, "R6 RAM latency after contended grant", lat, 7);
    check(rd === 16'hBEEF, "R9 RAM data after contended grant", rd, 16'hBEEF);
  endtask

  initial begin
    rstN = 1'b0; selN = 1'b1; strbN = 1'b1; engineBusy = 1'b0;
    memSel = 1'b0; rdWr = 1'b1; rdPol = 1'b1; addr = '0;
    tbDrive = '0; tbOe = 1'b0;
    repeat (3) @(posedge clk);
    #15 rstN = 1'b1;
    tick();
    tReset();
    tNoGrant();
    tRegRw();
    tRamRw();
    tPolarity();
    tDecode();
    tContention();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 50000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule